// File: doc/BRIEF.md
# Thermal Shutdown Power-State Controller

This block supervises the power state of a power management unit. It watches a digitized die temperature and three start-up request lines (a power button, a hands-free power line and a charger-present line). From these it drives one global enable for all regulators. Start-up is gated by temperature. A hot die trips the unit off, and a hysteresis band holds it off until the die has cooled well below the trip point.

What happens after a thermal trip depends on a software-controlled recovery bit. With the bit set, the unit waits for the die to cool and then powers up again on its own, keeping its register contents. With the bit clear, the unit shuts down fully and returns its registers to their defaults. It then stays off until a fresh request edge arrives. A read-only status register records which request lines started the unit. Registers are reached over a simple byte-wide bus: one write strobe, an address, write data, and combinational read data.

Top module: `thermal_power_supervisor`

## Requirements
- R1: After reset, `pwr_state` is OFF (encoding: OFF=0, STARTING=1, ACTIVE=2, TSD_WAIT=3, SHUTDOWN=4), `rail_en` is 0, and both registers read 0x00.
- R2: In OFF, a rising edge on any request input with a cool die moves the unit to STARTING at the next clock. `rail_en` is 1 in STARTING and ACTIVE. The unit enters ACTIVE after START_CYC (default 4) cycles in STARTING.
- R3: A start-up is refused while the last sampled temperature is at or above CLEAR_C (default 115). A value of exactly 115 still blocks.
- R4: A temperature above TRIP_C (default 160) seen while the rails are on turns `rail_en` off two clocks later. Exactly 160 does not trip.
- R5: Once tripped, the over-temperature condition persists until a sample below CLEAR_C. Samples from CLEAR_C up to TRIP_C keep the unit off.
- R6: With the auto-restart bit at 1, a trip leads to TSD_WAIT. The unit goes to STARTING one clock after the first cool sample has been registered, and the control and status registers keep their contents.
- R7: With the auto-restart bit at 0, a trip leads to SHUTDOWN for one cycle and then to OFF, with all registers back to their reset values. A request held high across the trip does not restart the unit; a new rising edge is needed.
- R8: The control register at address 0x1C holds the auto-restart enable in bit 1 (reset 0). Bits 7..2 and bit 0 read as 0 whatever is written.
- R9: The status register at address 0x0C is read-only. It sets bit 7 for the power button, bit 6 for hands-free power and bit 5 for the charger, with every line that had an edge in the start cycle set. It is cleared and reloaded at each new start from OFF. Bits 4..0 read 0.
- R10: Writes to 0x0C and to undefined addresses change nothing, and reads from undefined addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_c | input | TEMP_W (9) | Die temperature, signed, whole degrees Celsius |
| req_button | input | 1 | Power-button start-up request |
| req_handsfree | input | 1 | Hands-free power start-up request |
| req_charger | input | 1 | Charger-present start-up request |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| rail_en | output | 1 | Global regulator enable |
| pwr_state | output | 3 | Current power state code |

## Verification
The state sequence is driven with temperature and request patterns that sit on each side of both thresholds. The values 160 and 161 tell the trip boundary apart, and 114 and 115 tell the release boundary apart. Values between the thresholds show the hysteresis band holding the unit off. Requests are applied as fresh edges, as levels held across a trip, and as two lines rising in the same cycle. These separate edge-triggered starts from level-triggered ones and check that several status bits can be set together. The recovery bit is run at both settings and the registers are read back afterwards. This shows the difference between a restart that keeps state and a full shutdown that clears it.

// File: rtl/tps_pkg.sv
// Shared definitions for the thermal power-state supervisor.
// Assumes an 8-bit register address space with two defined registers.
package tps_pkg;

    // Power-state codes; the values are visible on the pwr_state port.
    typedef enum logic [2:0] {
        PS_OFF      = 3'd0,
        PS_STARTING = 3'd1,
        PS_ACTIVE   = 3'd2,
        PS_TSD_WAIT = 3'd3,
        PS_SHUTDOWN = 3'd4
    } pwr_state_e;

    // Number of start-up request sources: 0 button, 1 hands-free, 2 charger.
    localparam int SRC_N = 3;

    // Register addresses.
    localparam logic [7:0] ADDR_STATUS = 8'h0C;
    localparam logic [7:0] ADDR_CTRL   = 8'h1C;

    // Bit positions.
    localparam int CTRL_AUTO_BIT = 1;
    localparam int STATUS_MSB    = 7;

endpackage

// File: rtl/tps_temp_monitor.sv
// Temperature comparator with hysteresis.
// Samples the signed die temperature every clock. 'hot' sets on a sample
// above TRIP_C and clears only on a sample below CLEAR_C. 'cool_ok' says
// the last sample was below CLEAR_C. Assumes CLEAR_C < TRIP_C, both fit TEMP_W.
module tps_temp_monitor #(
    parameter int TEMP_W  = 9,
    parameter int TRIP_C  = 160,
    parameter int CLEAR_C = 115
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [TEMP_W-1:0] temp_c,
    output logic                     hot,
    output logic                     cool_ok
);

    localparam logic signed [TEMP_W-1:0] TRIP_T  = TEMP_W'(TRIP_C);
    localparam logic signed [TEMP_W-1:0] CLEAR_T = TEMP_W'(CLEAR_C);

    logic above_trip;
    logic below_clear;

    // Raw threshold compares on the live input.
    always_comb begin
        above_trip  = (temp_c > TRIP_T);
        below_clear = (temp_c < CLEAR_T);
    end

    // Hysteresis flag: set above trip, clear below release, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot <= 1'b0;
        end else if (above_trip) begin
            hot <= 1'b1;
        end else if (below_clear) begin
            hot <= 1'b0;
        end
    end

    // Start permission: conservatively low until the first cool sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cool_ok <= 1'b0;
        end else begin
            cool_ok <= below_clear;
        end
    end

endmodule

// File: rtl/tps_power_fsm.sv
// Power-state machine.
// Detects rising edges on the request inputs, starts the unit from OFF when
// the die is cool, times the STARTING phase, and handles thermal trips
// according to the auto-restart bit. Emits a capture strobe for the status
// register and a one-cycle soft clear for the register file.
module tps_power_fsm
    import tps_pkg::*;
#(
    parameter int N_SRC     = SRC_N,
    parameter int START_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req,
    input  logic             hot,
    input  logic             cool_ok,
    input  logic             auto_rst,
    output pwr_state_e       state,
    output logic             rail_en,
    output logic             capture,
    output logic [N_SRC-1:0] capture_src,
    output logic             soft_clear
);

    localparam int CNT_W = (START_CYC > 1) ? $clog2(START_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(START_CYC - 1);

    logic [N_SRC-1:0] req_q;
    logic [N_SRC-1:0] req_rise;
    logic [CNT_W-1:0] cnt;
    pwr_state_e       state_nx;

    // Remember last request levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req;
        end
    end

    // Rising edges and derived strobes.
    always_comb begin
        req_rise    = req & ~req_q;
        capture     = (state == PS_OFF) && (|req_rise) && cool_ok;
        capture_src = req_rise;
        soft_clear  = (state == PS_SHUTDOWN);
        rail_en     = (state == PS_STARTING) || (state == PS_ACTIVE);
    end

    // Next-state decision.
    always_comb begin
        state_nx = state;
        case (state)
            PS_OFF: begin
                if (capture) state_nx = PS_STARTING;
            end
            PS_STARTING: begin
                if (hot)                  state_nx = auto_rst ? PS_TSD_WAIT : PS_SHUTDOWN;
                else if (cnt == CNT_LAST) state_nx = PS_ACTIVE;
            end
            PS_ACTIVE: begin
                if (hot) state_nx = auto_rst ? PS_TSD_WAIT : PS_SHUTDOWN;
            end
            PS_TSD_WAIT: begin
                if (cool_ok) state_nx = PS_STARTING;
            end
            PS_SHUTDOWN: begin
                state_nx = PS_OFF;
            end
            default: state_nx = PS_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // STARTING phase timer: zero on entry, counts while starting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state != PS_STARTING) begin
            cnt <= '0;
        end else if (cnt != CNT_LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tps_reg_file.sv
// Control and status registers with a byte-wide bus.
// Control holds the auto-restart bit; status is read-only and loaded from the
// start-up capture strobe. A soft clear returns both to reset values. Reads
// are combinational; undefined addresses read zero and ignore writes.
module tps_reg_file
    import tps_pkg::*;
#(
    parameter int N_SRC = SRC_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             capture,
    input  logic [N_SRC-1:0] capture_src,
    input  logic             soft_clear,
    output logic             auto_rst,
    output logic [N_SRC-1:0] status_bits,
    output logic [7:0]       rdata
);

    logic [7:0] ctrl_byte;
    logic [7:0] status_byte;

    // Control register: only the auto-restart bit is stored.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clear) begin
            auto_rst <= 1'b0;
        end else if (wr_en && (addr == ADDR_CTRL)) begin
            auto_rst <= wdata[CTRL_AUTO_BIT];
        end
    end

    // Status register: reloaded as a whole at each start from OFF.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clear) begin
            status_bits <= '0;
        end else if (capture) begin
            status_bits <= capture_src;
        end
    end

    // Assemble the control read byte.
    always_comb begin
        ctrl_byte                = '0;
        ctrl_byte[CTRL_AUTO_BIT] = auto_rst;
    end

    // Place source i at bit STATUS_MSB - i.
    generate
        for (genvar i = 0; i < 8; i++) begin : g_status_map
            if ((i <= STATUS_MSB) && (i > STATUS_MSB - N_SRC)) begin : g_src
                assign status_byte[i] = status_bits[STATUS_MSB - i];
            end else begin : g_zero
                assign status_byte[i] = 1'b0;
            end
        end
    endgenerate

    // Read multiplexer.
    always_comb begin
        case (addr)
            ADDR_CTRL:   rdata = ctrl_byte;
            ADDR_STATUS: rdata = status_byte;
            default:     rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/thermal_power_supervisor.sv
// Top level of the thermal power-state supervisor.
// Joins the temperature monitor, the power-state machine and the register
// file. Assumes synchronous inputs; request lines are debounced upstream.
module thermal_power_supervisor
    import tps_pkg::*;
#(
    parameter int TEMP_W    = 9,
    parameter int TRIP_C    = 160,
    parameter int CLEAR_C   = 115,
    parameter int START_CYC = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [TEMP_W-1:0] temp_c,
    input  logic                     req_button,
    input  logic                     req_handsfree,
    input  logic                     req_charger,
    input  logic                     bus_wr,
    input  logic [7:0]               bus_addr,
    input  logic [7:0]               bus_wdata,
    output logic [7:0]               bus_rdata,
    output logic                     rail_en,
    output logic [2:0]               pwr_state
);

    logic             hot;
    logic             cool_ok;
    logic             auto_rst;
    logic             capture;
    logic             soft_clear;
    logic [SRC_N-1:0] req_vec;
    logic [SRC_N-1:0] capture_src;
    logic [SRC_N-1:0] status_bits;
    pwr_state_e       state;

    // Gather request lines in source-index order.
    always_comb begin
        req_vec   = {req_charger, req_handsfree, req_button};
        pwr_state = state;
    end

    tps_temp_monitor #(
        .TEMP_W (TEMP_W),
        .TRIP_C (TRIP_C),
        .CLEAR_C(CLEAR_C)
    ) u_temp (
        .clk    (clk),
        .rst_n  (rst_n),
        .temp_c (temp_c),
        .hot    (hot),
        .cool_ok(cool_ok)
    );

    tps_power_fsm #(
        .N_SRC    (SRC_N),
        .START_CYC(START_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req_vec),
        .hot        (hot),
        .cool_ok    (cool_ok),
        .auto_rst   (auto_rst),
        .state      (state),
        .rail_en    (rail_en),
        .capture    (capture),
        .capture_src(capture_src),
        .soft_clear (soft_clear)
    );

    tps_reg_file #(
        .N_SRC(SRC_N)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .capture    (capture),
        .capture_src(capture_src),
        .soft_clear (soft_clear),
        .auto_rst   (auto_rst),
        .status_bits(status_bits),
        .rdata      (bus_rdata)
    );

endmodule

// File: rtl/tps_checker.sv
// Assertion checker for the thermal power-state supervisor, bound to the top.
// Observes ports plus the cool flag, auto-restart bit and status bits.
module tps_checker
    import tps_pkg::*;
#(
    parameter int TEMP_W = 9,
    parameter int TRIP_C = 160
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic signed [TEMP_W-1:0] temp_c,
    input logic                     rail_en,
    input logic [2:0]               pwr_state,
    input logic                     cool_ok,
    input logic                     auto_rst,
    input logic [SRC_N-1:0]         status_bits
);

    localparam logic signed [TEMP_W-1:0] TRIP_T = TEMP_W'(TRIP_C);

    // R4
    trip_rails_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en && (temp_c > TRIP_T)) |=> ##1 !rail_en);

    // R3
    no_start_warm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_state == PS_OFF) && !cool_ok) |=> (pwr_state == PS_OFF));

    // R6
    auto_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_state == PS_TSD_WAIT) && cool_ok) |=> (pwr_state == PS_STARTING));

    // R7
    shutdown_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_SHUTDOWN) |=> ((pwr_state == PS_OFF) && !auto_rst && (status_bits == '0)));

    // R9
    start_records_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_state == PS_STARTING) && ($past(pwr_state) == PS_OFF)) |-> (status_bits != '0));

endmodule

bind thermal_power_supervisor tps_checker #(
    .TEMP_W(TEMP_W),
    .TRIP_C(TRIP_C)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .temp_c     (temp_c),
    .rail_en    (rail_en),
    .pwr_state  (pwr_state),
    .cool_ok    (cool_ok),
    .auto_rst   (auto_rst),
    .status_bits(status_bits)
);

// File: tb/sim_thermal_power_supervisor.sv
module sim_thermal_power_supervisor;

    localparam int ST_OFF = 0, ST_START = 1, ST_ACT = 2, ST_WAIT = 3, ST_SHUT = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic signed [8:0] temp_c = 9'sd25;
    logic              req_button = 1'b0, req_handsfree = 1'b0, req_charger = 1'b0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0]        bus_rdata;
    logic              rail_en;
    logic [2:0]        pwr_state;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    thermal_power_supervisor u0 (
        .clk(clk), .rst_n(rst_n), .temp_c(temp_c),
        .req_button(req_button), .req_handsfree(req_handsfree), .req_charger(req_charger),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rail_en(rail_en), .pwr_state(pwr_state)
    );

    typedef struct packed {
        logic signed [8:0] temp;
        logic [2:0]        req;   // {charger, handsfree, button}
        logic [3:0]        cyc;
        logic [2:0]        st;
        logic              rail;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{9'sd25,  3'b000, 4'd2, 3'd0, 1'b0},  // warm-up, OFF (R1)
        '{9'sd25,  3'b001, 4'd1, 3'd1, 1'b1},  // button edge -> STARTING (R2)
        '{9'sd25,  3'b001, 4'd4, 3'd2, 1'b1},  // after START_CYC -> ACTIVE (R2)
        '{9'sd160, 3'b000, 4'd3, 3'd2, 1'b1},  // exactly 160 no trip (R4)
        '{9'sd161, 3'b000, 4'd2, 3'd4, 1'b0},  // trip, auto off -> SHUTDOWN (R4, R7)
        '{9'sd161, 3'b000, 4'd1, 3'd0, 1'b0},  // SHUTDOWN -> OFF (R7)
        '{9'sd120, 3'b001, 4'd2, 3'd0, 1'b0},  // edge while warm blocked (R3, R5)
        '{9'sd115, 3'b000, 4'd2, 3'd0, 1'b0},  // 115 still blocks (R3)
        '{9'sd115, 3'b010, 4'd2, 3'd0, 1'b0},  // hands-free edge at 115 blocked (R3)
        '{9'sd114, 3'b010, 4'd2, 3'd0, 1'b0},  // held level, cool: no start (R7)
        '{9'sd114, 3'b000, 4'd1, 3'd0, 1'b0},
        '{9'sd114, 3'b110, 4'd1, 3'd1, 1'b1},  // two edges together -> STARTING (R2, R9)
        '{9'sd114, 3'b000, 4'd4, 3'd2, 1'b1}   // -> ACTIVE (R2)
    };

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input string tag, input int exp);
        bus_addr = a;
        #1;
        check(tag, int'(bus_rdata), exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 state", int'(pwr_state), ST_OFF);
        check("R1 rail", int'(rail_en), 0);
        rd(8'h1C, "R1 ctrl", 8'h00);
        rd(8'h0C, "R1 status", 8'h00);

        for (int i = 0; i < NV; i++) begin
            temp_c = VECS[i].temp;
            {req_charger, req_handsfree, req_button} = VECS[i].req;
            step(int'(VECS[i].cyc));
            check($sformatf("R2-table row %0d state", i), int'(pwr_state), int'(VECS[i].st));
            check($sformatf("R4-table row %0d rail", i), int'(rail_en), int'(VECS[i].rail));
        end
        {req_charger, req_handsfree, req_button} = 3'b000;

        // R9 both lines recorded, low bits zero
        rd(8'h0C, "R9 status two sources", 8'h60);
        // R10 undefined read, ignored writes
        rd(8'h44, "R10 undefined read", 8'h00);
        wr(8'h0C, 8'hFF);
        rd(8'h0C, "R10 status write ignored", 8'h60);
        wr(8'h55, 8'hFF);
        rd(8'h55, "R10 undefined write ignored", 8'h00);
        rd(8'h1C, "R10 ctrl untouched by undefined write", 8'h00);
        // R8 only bit 1 stored
        wr(8'h1C, 8'hFF);
        rd(8'h1C, "R8 ctrl readback", 8'h02);

        // R6 auto restart path
        temp_c = 9'sd170;
        step(2);
        check("R6 enter TSD_WAIT", int'(pwr_state), ST_WAIT);
        check("R6 rails off", int'(rail_en), 0);
        temp_c = 9'sd130;
        step(3);
        check("R5 held in band", int'(pwr_state), ST_WAIT);
        temp_c = 9'sd115;
        step(2);
        check("R5 held at 115", int'(pwr_state), ST_WAIT);
        temp_c = 9'sd100;
        step(2);
        check("R6 restart", int'(pwr_state), ST_START);
        check("R6 rails on", int'(rail_en), 1);
        rd(8'h1C, "R6 ctrl kept", 8'h02);
        rd(8'h0C, "R6 status kept", 8'h60);
        step(4);
        check("R6 active again", int'(pwr_state), ST_ACT);

        // R7 full shutdown clears registers
        wr(8'h1C, 8'h00);
        temp_c = 9'sd170;
        step(1);
        check("R7 still active one cycle after hot", int'(pwr_state), ST_ACT);
        step(1);
        check("R7 shutdown", int'(pwr_state), ST_SHUT);
        step(1);
        check("R7 off", int'(pwr_state), ST_OFF);
        rd(8'h0C, "R7 status cleared", 8'h00);

        // R9 new start reloads status with button only
        temp_c = 9'sd25;
        step(2);
        req_button = 1'b1;
        step(1);
        check("R9 start by button", int'(pwr_state), ST_START);
        rd(8'h0C, "R9 status button only", 8'h80);
        req_button = 1'b0;

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule